// File: doc/BRIEF.md
# Indirect Serial-Controller Register Command Bridge

This block gives a 64-bit host register window access to a small bank of 8-bit registers inside a two-wire serial bus controller. The host never addresses those registers directly. Instead it writes a single command word. That word holds a launch flag in bit 63, a direction flag, a 4-bit opcode, a 3-bit internal register index and a 32-bit data field. The bridge performs the access and then clears the launch flag. The host polls the word until the flag reads 0. After a read, the fetched byte is found in the low data bits of the same word.

The serial bus engine is not part of this block. A register-bank stub stands in for it. Each internal access takes a fixed, parameterised number of cycles, so the host must really poll. Index 3 is shared by two registers: a write to it goes to the clock-divider configuration, which is brought out on a port, and a read from it returns a constant bus-idle status code. Index 7 is a soft reset for the bank.

The sequencer has three states. ST_IDLE waits for a launch. ST_ACCESS counts down the access latency. ST_BYPASS completes an unsupported opcode. Its transitions are:
- ST_IDLE to ST_ACCESS on a launch with opcode 6.
- ST_IDLE to ST_BYPASS on a launch with any other opcode.
- ST_ACCESS to ST_IDLE when the countdown reaches zero.
- ST_BYPASS to ST_IDLE unconditionally.

Top module: `twsi_cmd_bridge`

## Requirements
- R1: After reset the readable command word is all zeros and the clock-divider configuration output is 0.
- R2: A host write whose bit 63 is 1, accepted while the held word's bit 63 is 0, launches an access. Bit 63 then reads 1. For opcode 6 (bits 60:57) it returns to 0 exactly ACC_LAT cycles after the launching edge.
- R3: A host write arriving while the held word's bit 63 is 1 is ignored: the held word and the outcome of the running access are those of the earlier command.
- R4: With opcode 6 and bit 56 = 0 (write), byte data[7:0] is stored in the register chosen by bits 34:32. Indices 0, 1, 2 and 4 are read/write. The data field of the command word is left unchanged on completion.
- R5: With opcode 6 and bit 56 = 1 (read), completion places the selected byte in data[7:0] and zeros data[31:8]. Bits 62:32 of the word are kept.
- R6: Index 3 is direction-dependent. A write sets the clock-divider configuration output. A read returns the status constant STATUS_IDLE (default 0xF8), never the written value.
- R7: A write to index 7 clears registers 0 to 4, including the clock-divider configuration. Reads of indices 5, 6 and 7 return 0.
- R8: An opcode other than 6 clears bit 63 on the first edge after the launch and zeros data[31:0]. It leaves every internal register unchanged.
- R9: A host write with bit 63 = 0, made while idle, is stored as the held word as is, and performs no internal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_en | input | 1 | Host write strobe for the command window |
| cmd_wr_word | input | 64 | Command word written by the host |
| cmd_rd_word | output | 64 | Held command word as read back by the host |
| clk_cfg | output | 8 | Clock-divider configuration for the serial engine |

## Verification
Directed commands run through each index in both directions. This separates the shared index 3 (clock configuration against status), the read/write registers, and the unused indices 5 to 7.

Further patterns target specific faults:
- Polling latency is measured per command, which separates the counted access from the one-cycle bypass of other opcodes.
- A second write during a busy access shows whether the held command can be overwritten.
- A soft reset followed by read-backs shows whether every register is cleared.
- A write with the launch flag clear shows whether storing a word can trigger an access.

Seeded random commands mix opcodes, directions, indices and payloads. Each result is compared against a bench model of the bank.

// File: rtl/twsi_bridge_pkg.sv
package twsi_bridge_pkg;
    localparam int CMD_W   = 64;
    localparam int DATA_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int V_BIT   = 63;
    localparam int R_BIT   = 56;
    localparam int OP_LSB  = 57;
    localparam int OP_W    = 4;
    localparam int IDX_LSB = 32;
    localparam int IDX_W   = 3;
    localparam int NUM_STORED = 5;

    localparam logic [OP_W-1:0] OP_REG_ACCESS = 4'd6;

    typedef enum logic [IDX_W-1:0] {
        IDX_SADDR    = 3'd0,
        IDX_DATA     = 3'd1,
        IDX_CTRL     = 3'd2,
        IDX_CLK_STAT = 3'd3,
        IDX_SADDR_X  = 3'd4,
        IDX_RSV5     = 3'd5,
        IDX_RSV6     = 3'd6,
        IDX_SOFT_RST = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic              valid;
        logic              is_read;
        logic [OP_W-1:0]   opcode;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] wbyte;
    } cmd_fields_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_BYPASS = 2'd2
    } seq_state_e;
endpackage

// File: rtl/twsi_cmd_decode.sv
module twsi_cmd_decode
    import twsi_bridge_pkg::*;
(
    input  logic [CMD_W-1:0] word,
    output cmd_fields_t      fields,
    output logic             is_reg_op
);
    always_comb begin
        fields.valid   = word[V_BIT];
        fields.is_read = word[R_BIT];
        fields.opcode  = word[OP_LSB +: OP_W];
        fields.idx     = word[IDX_LSB +: IDX_W];
        fields.wbyte   = word[BYTE_W-1:0];
        is_reg_op      = (word[OP_LSB +: OP_W] == OP_REG_ACCESS);
    end
endmodule

// File: rtl/twsi_reg_bank.sv
module twsi_reg_bank
    import twsi_bridge_pkg::*;
#(
    parameter logic [7:0] STATUS_IDLE = 8'hF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] rbyte,
    output logic [BYTE_W-1:0] clk_cfg
);
    logic [BYTE_W-1:0] regs [NUM_STORED];

    for (genvar i = 0; i < NUM_STORED; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && idx == IDX_SOFT_RST) begin
                regs[i] <= '0;
            end else if (we && idx == IDX_W'(i)) begin
                regs[i] <= wbyte;
            end
        end
    end

    always_comb begin
        unique case (idx)
            IDX_SADDR:    rbyte = regs[0];
            IDX_DATA:     rbyte = regs[1];
            IDX_CTRL:     rbyte = regs[2];
            IDX_CLK_STAT: rbyte = STATUS_IDLE;
            IDX_SADDR_X:  rbyte = regs[4];
            default:      rbyte = '0;
        endcase
    end

    assign clk_cfg = regs[IDX_CLK_STAT];
endmodule

// File: rtl/twsi_bridge_seq.sv
module twsi_bridge_seq
    import twsi_bridge_pkg::*;
#(
    parameter int ACC_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic is_reg_op,
    output logic done,
    output logic reg_done
);
    localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        done     = 1'b0;
        reg_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) begin
                    state_d = is_reg_op ? ST_ACCESS : ST_BYPASS;
                    cnt_d   = CNT_W'(ACC_LAT - 1);
                end
            end
            ST_ACCESS: begin
                if (cnt_q == '0) begin
                    done     = 1'b1;
                    reg_done = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_BYPASS: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/twsi_cmd_bridge.sv
module twsi_cmd_bridge
    import twsi_bridge_pkg::*;
#(
    parameter int         ACC_LAT     = 4,
    parameter logic [7:0] STATUS_IDLE = 8'hF8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr_en,
    input  logic [63:0] cmd_wr_word,
    output logic [63:0] cmd_rd_word,
    output logic [7:0]  clk_cfg
);
    logic [CMD_W-1:0]  cmd_q;
    cmd_fields_t       in_f, held_f;
    logic              in_reg_op, held_reg_op;
    logic              accept, launch, done, reg_done;
    logic              bank_we;
    logic [BYTE_W-1:0] rbyte;

    twsi_cmd_decode u_dec_in (
        .word(cmd_wr_word), .fields(in_f), .is_reg_op(in_reg_op)
    );
    twsi_cmd_decode u_dec_held (
        .word(cmd_q), .fields(held_f), .is_reg_op(held_reg_op)
    );

    assign accept  = cmd_wr_en && !cmd_q[V_BIT];
    assign launch  = accept && in_f.valid;
    assign bank_we = reg_done && held_reg_op && !held_f.is_read;

    twsi_bridge_seq #(.ACC_LAT(ACC_LAT)) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .is_reg_op(in_reg_op),
        .done(done), .reg_done(reg_done)
    );

    twsi_reg_bank #(.STATUS_IDLE(STATUS_IDLE)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(bank_we), .idx(held_f.idx),
        .wbyte(held_f.wbyte), .rbyte(rbyte), .clk_cfg(clk_cfg)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= cmd_wr_word;
        end else if (done) begin
            cmd_q[V_BIT] <= 1'b0;
            if (!reg_done) begin
                cmd_q[DATA_W-1:0] <= '0;
            end else if (held_f.is_read) begin
                cmd_q[DATA_W-1:0] <= {{(DATA_W-BYTE_W){1'b0}}, rbyte};
            end
        end
    end

    assign cmd_rd_word = cmd_q;
endmodule

// File: rtl/twsi_bridge_chk.sv
module twsi_bridge_chk #(
    parameter int ACC_LAT = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr_en,
    input logic [63:0] cmd_wr_word,
    input logic [63:0] cmd_rd_word,
    input logic [7:0]  clk_cfg
);
    localparam int VC_W = $clog2(ACC_LAT + 2) + 1;
    logic [VC_W-1:0] vcnt;
    logic            acc;

    assign acc = cmd_wr_en && !cmd_rd_word[63];

    always_ff @(posedge clk) begin
        if (!rst_n || !cmd_rd_word[63]) vcnt <= '0;
        else if (vcnt != '1) vcnt <= vcnt + 1'b1;
    end

    AST_LAUNCH_SETS_V: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_wr_word[63] |=> cmd_rd_word[63]); // R2
    AST_ACCESS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_rd_word[63]) && cmd_rd_word[60:57] == 4'd6 |-> vcnt == VC_W'(ACC_LAT)); // R2
    AST_BUSY_HOLDS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd_word[63] |=> $stable(cmd_rd_word[62:32])); // R3
    AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_rd_word[63]) && cmd_rd_word[60:57] == 4'd6 && !cmd_rd_word[56]
        |-> cmd_rd_word[31:0] == $past(cmd_rd_word[31:0])); // R4
    AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_rd_word[63]) && cmd_rd_word[60:57] == 4'd6 && cmd_rd_word[56]
        |-> cmd_rd_word[31:8] == 24'd0); // R5
    AST_CFG_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_cfg) |-> $fell(cmd_rd_word[63])); // R6
    AST_BYPASS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_wr_word[63] && cmd_wr_word[60:57] != 4'd6
        |=> ##1 !cmd_rd_word[63] && cmd_rd_word[31:0] == 32'd0); // R8
    AST_PASSIVE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !cmd_wr_word[63] |=> cmd_rd_word == $past(cmd_wr_word)); // R9
endmodule

bind twsi_cmd_bridge twsi_bridge_chk #(.ACC_LAT(ACC_LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_word(cmd_wr_word),
    .cmd_rd_word(cmd_rd_word), .clk_cfg(clk_cfg)
);

// File: tb/tb_twsi_cmd_bridge.sv
module tb_twsi_cmd_bridge;
    localparam int         CLK_PERIOD = 10;
    localparam int         ACC_LAT    = 4;
    localparam logic [7:0] STAT_IDLE  = 8'hF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr_en = 1'b0;
    logic [63:0] cmd_wr_word = '0;
    logic [63:0] cmd_rd_word;
    logic [7:0]  clk_cfg;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [5];

    twsi_cmd_bridge #(.ACC_LAT(ACC_LAT), .STATUS_IDLE(STAT_IDLE)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_word(cmd_wr_word),
        .cmd_rd_word(cmd_rd_word), .clk_cfg(clk_cfg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [3:0] op, input bit rd, input logic [2:0] idx,
                                       input logic [31:0] data, input logic [63:0] filler);
        logic [63:0] w = filler;
        w[63] = 1'b1; w[56] = rd; w[60:57] = op; w[34:32] = idx; w[31:0] = data;
        return w;
    endfunction

    function automatic logic [7:0] mdl_rd(input logic [2:0] idx);
        if (idx == 3'd3) return STAT_IDLE;
        if (idx < 3'd5) return mdl[idx];
        return 8'h00;
    endfunction

    function automatic logic [63:0] exp_word(input logic [63:0] w);
        logic [63:0] r = w;
        r[63] = 1'b0;
        if (w[60:57] != 4'd6) r[31:0] = '0;
        else if (w[56]) r[31:0] = {24'd0, mdl_rd(w[34:32])};
        return r;
    endfunction

    function automatic void mdl_apply(input logic [63:0] w);
        if (w[60:57] == 4'd6 && !w[56]) begin
            if (w[34:32] == 3'd7) begin
                for (int i = 0; i < 5; i++) mdl[i] = 8'h00;
            end else if (w[34:32] < 3'd5) begin
                mdl[w[34:32]] = w[7:0];
            end
        end
    endfunction

    task automatic host_wr(input logic [63:0] w);
        @(negedge clk);
        cmd_wr_en = 1'b1; cmd_wr_word = w;
        @(negedge clk);
        cmd_wr_en = 1'b0;
    endtask

    task automatic run_cmd(input logic [63:0] w, output logic [63:0] res, output int lat);
        host_wr(w);
        lat = 0;
        while (cmd_rd_word[63] && lat < 1000) begin
            lat++;
            @(negedge clk);
        end
        res = cmd_rd_word;
    endtask

    task automatic do_and_check(input logic [63:0] w, input string req);
        logic [63:0] res, exp;
        int lat;
        exp = exp_word(w);
        run_cmd(w, res, lat);
        mdl_apply(w);
        chk(res == exp, req, res, exp);
        chk(lat == ((w[60:57] == 4'd6) ? ACC_LAT : 1), {req, " R2 latency"}, 64'(lat),
            64'((w[60:57] == 4'd6) ? ACC_LAT : 1));
        chk(clk_cfg == mdl[3], {req, " clk_cfg"}, 64'(clk_cfg), 64'(mdl[3]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] res, w1, w2;
        int lat;
        void'($urandom(32'd1234));
        for (int i = 0; i < 5; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_rd_word == 64'd0, "R1 word", cmd_rd_word, 64'd0);
        chk(clk_cfg == 8'd0, "R1 clk_cfg", 64'(clk_cfg), 64'd0);

        // R4 writes then R5 reads on stored indices
        do_and_check(mk(4'd6, 1'b0, 3'd0, 32'hABCD_0011, 64'h0), "R4 w0");
        do_and_check(mk(4'd6, 1'b0, 3'd1, 32'h0000_0022, 64'h0), "R4 w1");
        do_and_check(mk(4'd6, 1'b0, 3'd2, 32'h0000_0033, 64'h0), "R4 w2");
        do_and_check(mk(4'd6, 1'b0, 3'd4, 32'h0000_0044, 64'h0), "R4 w4");
        do_and_check(mk(4'd6, 1'b1, 3'd0, 32'hFFFF_FFFF, 64'h5555_5555_5555_5555), "R5 r0");
        do_and_check(mk(4'd6, 1'b1, 3'd1, 32'h0, 64'h0), "R5 r1");
        do_and_check(mk(4'd6, 1'b1, 3'd2, 32'h0, 64'h0), "R5 r2");
        do_and_check(mk(4'd6, 1'b1, 3'd4, 32'h0, 64'h0), "R5 r4");

        // R6 shared index 3
        do_and_check(mk(4'd6, 1'b0, 3'd3, 32'h0000_005A, 64'h0), "R6 write clk");
        chk(clk_cfg == 8'h5A, "R6 clk_cfg value", 64'(clk_cfg), 64'h5A);
        do_and_check(mk(4'd6, 1'b1, 3'd3, 32'h0, 64'h0), "R6 read status");
        chk(cmd_rd_word[7:0] == STAT_IDLE, "R6 status byte", 64'(cmd_rd_word[7:0]), 64'(STAT_IDLE));

        // R3 write during busy ignored
        w1 = mk(4'd6, 1'b0, 3'd1, 32'h0000_0077, 64'h0);
        w2 = mk(4'd6, 1'b0, 3'd1, 32'h0000_0099, 64'h0);
        host_wr(w1);
        host_wr(w2);
        chk(cmd_rd_word == w1, "R3 held word", cmd_rd_word, w1);
        while (cmd_rd_word[63]) @(negedge clk);
        mdl_apply(w1);
        chk(cmd_rd_word == exp_word(w1), "R3 outcome", cmd_rd_word, exp_word(w1));
        do_and_check(mk(4'd6, 1'b1, 3'd1, 32'h0, 64'h0), "R3 readback");
        chk(cmd_rd_word[7:0] == 8'h77, "R3 byte", 64'(cmd_rd_word[7:0]), 64'h77);

        // R8 other opcode
        do_and_check(mk(4'd2, 1'b0, 3'd0, 32'hDEAD_BEEF, 64'h0), "R8 op2 write");
        do_and_check(mk(4'd6, 1'b1, 3'd0, 32'h0, 64'h0), "R8 bank kept");
        chk(cmd_rd_word[7:0] == 8'h11, "R8 byte", 64'(cmd_rd_word[7:0]), 64'h11);

        // R9 passive store
        w1 = mk(4'd6, 1'b0, 3'd0, 32'h0000_00EE, 64'h0);
        w1[63] = 1'b0;
        host_wr(w1);
        chk(cmd_rd_word == w1, "R9 stored", cmd_rd_word, w1);
        repeat (ACC_LAT + 2) @(negedge clk);
        do_and_check(mk(4'd6, 1'b1, 3'd0, 32'h0, 64'h0), "R9 no access");
        chk(cmd_rd_word[7:0] == 8'h11, "R9 byte", 64'(cmd_rd_word[7:0]), 64'h11);

        // R7 soft reset and unused indices
        do_and_check(mk(4'd6, 1'b0, 3'd7, 32'h0, 64'h0), "R7 soft reset");
        chk(clk_cfg == 8'h00, "R7 clk_cfg cleared", 64'(clk_cfg), 64'h0);
        for (int k = 0; k < 8; k++)
            do_and_check(mk(4'd6, 1'b1, 3'(k), 32'hFFFF_FFFF, 64'h0), "R7 readback");

        // random mix
        for (int n = 0; n < 80; n++) begin
            logic [3:0] op;
            op = ($urandom % 4 != 0) ? 4'd6 : 4'($urandom);
            do_and_check(mk(op, 1'($urandom), 3'($urandom), $urandom,
                            {$urandom, $urandom}), "R4 R5 R8 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule